// File: doc/BRIEF.md
# Selectable Pipeline/Flow-Through SRAM Read Output Path

This block forms the read-data and output-enable timing stage of a synchronous burst SRAM model. Each cycle it takes one already-registered command from the input stage and one word of read data from the core array. From these it produces the data bus value and the bus enable. The core delivers the data for a read in the cycle after the read command.

Two static mode inputs set the timing. One chooses pipelined output, where data passes through an output register, or flow-through output, where the register is bypassed and latency is one cycle shorter. The other chooses single-cycle or dual-cycle deselect. In dual-cycle mode the bus keeps its previous state for one extra cycle after a deselect, then turns off. An asynchronous active-low output enable and an active-high sleep input both gate the bus directly. While sleep is high, every command entering the path is taken as a deselect.

Top module: `sram_read_out`

## Requirements
- R1: After reset, and before any read reaches its output slot, dq_oe is 0 and dq_out is 0.
- R2: In pipelined mode (mode_pipe=1), a read (cmd_in=2'b01) in cycle t drives dq_oe=1 in cycle t+2, and dq_out carries the core_rdata value presented in cycle t+1.
- R3: In flow-through mode (mode_pipe=0), a read in cycle t drives dq_oe=1 in cycle t+1, and dq_out follows core_rdata of that same cycle combinationally.
- R4: In single-cycle deselect mode (mode_dcd=0), a deselect (cmd_in=2'b00) in cycle t turns dq_oe off in the read slot of cycle t (t+2 when pipelined, t+1 when flow-through).
- R5: In dual-cycle deselect mode (mode_dcd=1), the slot of a deselect keeps the enable state and data of the slot before it whenever the previous command was not a deselect. The slot is off when the previous command was also a deselect.
- R6: A write (cmd_in=2'b10) never enables the bus: its slot is off in every mode.
- R7: A hold/continue command (cmd_in=2'b11) repeats the most recent effective command. Directly after reset it acts as a deselect.
- R8: oe_n=1 forces dq_oe to 0 in the same cycle, without waiting for a clock edge.
- R9: zz=1 forces dq_oe to 0 in the same cycle. A command presented while zz=1 is taken as a deselect.
- R10: In pipelined mode the output register loads only in the cycle after a read. Otherwise dq_out keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_pipe | input | 1 | 1 = pipelined output, 0 = flow-through (static) |
| mode_dcd | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle (static) |
| oe_n | input | 1 | Asynchronous active-low output enable |
| zz | input | 1 | Sleep request, active high |
| cmd_in | input | 2 | Registered command: 00 deselect, 01 read, 10 write, 11 hold |
| core_rdata | input | DW | Core read data, valid the cycle after a read |
| dq_out | output | DW | Data bus value |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The assertions check on every cycle the slot rules that depend on the command history alone. These are: reads turn the slot on, writes and single-cycle deselects turn it off, and a dual-cycle deselect keeps the previous slot. They also check the asynchronous gating by oe_n and zz, sleep-time commands becoming deselects, and the output register holding between reads. Only the bench scenarios can show the absolute latencies of the four mode combinations and that the data seen on the bus is the correct core word. The same applies to how hold commands resolve, and to back-to-back read/deselect/read and write-then-read sequences, which the bench checks against its cycle model.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    CMD_DESEL = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_HOLD  = 2'b11
  } cmd_e;

  localparam int HIST = 3;
endpackage

// File: rtl/srp_cmd_track.sv
module srp_cmd_track
  import srp_pkg::*;
#(
  parameter int DEPTH = HIST
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   zz,
  input  logic [1:0]             cmd_in,
  output logic [DEPTH:0][1:0]    eff_hist
);
  logic [1:0] last_q;
  logic [1:0] resolved;

  always_comb begin
    resolved    = (cmd_in == CMD_HOLD) ? last_q : cmd_in;
    eff_hist[0] = zz ? CMD_DESEL : resolved;
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= CMD_DESEL;
    else     last_q <= eff_hist[0];
  end

  for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) eff_hist[i] <= CMD_DESEL;
      else     eff_hist[i] <= eff_hist[i-1];
    end
  end

  AST_SLEEP_AS_DESEL: assert property (@(posedge clk) disable iff (rst)
    zz |=> (eff_hist[1] == CMD_DESEL)); // R9
endmodule

// File: rtl/srp_oe_pipe.sv
module srp_oe_pipe
  import srp_pkg::*;
#(
  parameter int DEPTH = HIST
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pipe,
  input  logic                dcd,
  input  logic [DEPTH:0][1:0] eff_hist,
  output logic                oe_slot
);
  logic [1:0] e_slot;
  logic [1:0] e_prev;
  logic       slot_q;

  always_comb begin
    e_slot = pipe ? eff_hist[2] : eff_hist[1];
    e_prev = pipe ? eff_hist[3] : eff_hist[2];
    unique case (e_slot)
      CMD_READ:  oe_slot = 1'b1;
      CMD_DESEL: oe_slot = (dcd && e_prev != CMD_DESEL) ? slot_q : 1'b0;
      default:   oe_slot = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) slot_q <= 1'b0;
    else     slot_q <= oe_slot;
  end

  AST_READ_SLOT_ON: assert property (@(posedge clk) disable iff (rst)
    (e_slot == CMD_READ) |-> oe_slot); // R2
  AST_WRITE_SLOT_OFF: assert property (@(posedge clk) disable iff (rst)
    (e_slot == CMD_WRITE) |-> !oe_slot); // R6
  AST_SCD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!dcd && e_slot == CMD_DESEL) |-> !oe_slot); // R4
  AST_DCD_KEEP: assert property (@(posedge clk) disable iff (rst)
    (dcd && e_slot == CMD_DESEL && e_prev != CMD_DESEL) |-> (oe_slot == slot_q)); // R5
endmodule

// File: rtl/srp_data_path.sv
module srp_data_path #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pipe,
  input  logic          rd_d1,
  input  logic [DW-1:0] core_rdata,
  output logic [DW-1:0] dq_data
);
  logic [DW-1:0] dq_q;

  always_ff @(posedge clk) begin
    if (rst)        dq_q <= '0;
    else if (rd_d1) dq_q <= core_rdata;
  end

  assign dq_data = (!pipe && rd_d1) ? core_rdata : dq_q;

  AST_REG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_d1 |=> $stable(dq_q)); // R10
endmodule

// File: rtl/sram_read_out.sv
module sram_read_out
  import srp_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_pipe,
  input  logic          mode_dcd,
  input  logic          oe_n,
  input  logic          zz,
  input  logic [1:0]    cmd_in,
  input  logic [DW-1:0] core_rdata,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  logic [HIST:0][1:0] eff_hist;
  logic               oe_slot;
  logic               rd_d1;

  srp_cmd_track #(.DEPTH(HIST)) u_track (
    .clk(clk), .rst(rst), .zz(zz), .cmd_in(cmd_in), .eff_hist(eff_hist)
  );

  srp_oe_pipe #(.DEPTH(HIST)) u_oe (
    .clk(clk), .rst(rst), .pipe(mode_pipe), .dcd(mode_dcd),
    .eff_hist(eff_hist), .oe_slot(oe_slot)
  );

  assign rd_d1 = (eff_hist[1] == CMD_READ);

  srp_data_path #(.DW(DW)) u_data (
    .clk(clk), .rst(rst), .pipe(mode_pipe), .rd_d1(rd_d1),
    .core_rdata(core_rdata), .dq_data(dq_out)
  );

  assign dq_oe = oe_slot & ~oe_n & ~zz;

  AST_ASYNC_GATE: assert property (@(posedge clk) disable iff (rst)
    (oe_n || zz) |-> !dq_oe); // R8 R9
endmodule

// File: tb/tb_sram_read_out.sv
`timescale 1ns/1ps
module tb_sram_read_out;
  localparam int DW = 36;
  localparam logic [1:0] DS = 2'b00, RD = 2'b01, WR = 2'b10, HD = 2'b11;
  localparam int NSEQ = 34;

  logic clk = 0, rst = 1, mode_pipe = 1, mode_dcd = 0, oe_n = 0, zz = 0;
  logic [1:0] cmd_in = DS;
  logic [DW-1:0] core_rdata = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  sram_read_out #(.DW(DW)) dut (
    .clk(clk), .rst(rst), .mode_pipe(mode_pipe), .mode_dcd(mode_dcd),
    .oe_n(oe_n), .zz(zz), .cmd_in(cmd_in), .core_rdata(core_rdata),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [1:0] hist [0:63];
  logic [1:0] raw [0:63];
  logic [DW-1:0] core [0:63];
  int n;
  logic [1:0] lastc;
  logic slotprev;

  function automatic logic [1:0] seq_cmd(input int i);
    case (i)
      0: return RD;  1: return RD;  2: return DS;  3: return RD;
      4: return DS;  5: return DS;  6: return RD;  7: return WR;
      8: return RD;  9: return HD;  10: return HD; 11: return DS;
      12: return HD; 13: return DS; 14: return RD; 15: return WR;
      16: return WR; 17: return RD; 18: return DS; 19: return RD;
      20: return RD; 21: return DS; 22: return DS; 23: return RD;
      24: return RD; 25: return DS; 26: return RD; 27: return HD;
      default: return DS;
    endcase
  endfunction

  function automatic logic [1:0] get_h(input int k);
    return (k < 0) ? DS : hist[k];
  endfunction

  task automatic report(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual=%h expected=%h", tag, what, n, act, exp);
    end
  endtask

  task automatic do_reset(input logic p, input logic d);
    rst = 1; mode_pipe = p; mode_dcd = d; cmd_in = DS; zz = 0; oe_n = 0; core_rdata = '0;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    n = 0; lastc = DS; slotprev = 0;
    #1;
    report("R1", "oe after reset", {35'b0, dq_oe}, '0);
    report("R1", "data after reset", dq_out, '0);
  endtask

  task automatic step(input logic [1:0] c, input logic z, input logic g);
    logic [1:0] r, e, eL, eL1;
    logic slot, exp_oe;
    logic [DW-1:0] exp_d;
    int L;
    string tag;
    cmd_in = c; zz = z; oe_n = g;
    core[n] = {4'h5, 32'(n * 32'h9E3779B1 + (mode_pipe ? 32'h100 : 0) + (mode_dcd ? 32'h7 : 0))};
    core_rdata = core[n];
    raw[n] = c;
    r = (c == HD) ? lastc : c;
    e = z ? DS : r;
    lastc = e;
    hist[n] = e;
    L = mode_pipe ? 2 : 1;
    eL = get_h(n - L);
    eL1 = get_h(n - L - 1);
    case (eL)
      RD: slot = 1;
      WR: slot = 0;
      default: slot = (mode_dcd && eL1 != DS) ? slotprev : 1'b0;
    endcase
    exp_oe = slot && !g && !z;
    exp_d = '0;
    for (int k = n - L; k >= 0; k--) begin
      if (hist[k] == RD) begin exp_d = core[k + 1]; break; end
    end
    if (z) tag = "R9";
    else if (g) tag = "R8";
    else if (n - L >= 0 && raw[n - L] == HD) tag = "R7";
    else if (eL == WR) tag = "R6";
    else if (eL == DS) tag = mode_dcd ? "R5" : "R4";
    else tag = mode_pipe ? "R2" : "R3";
    #2;
    report(tag, "dq_oe", {35'b0, dq_oe}, {35'b0, exp_oe});
    if (exp_oe) report(mode_pipe ? "R10" : "R3", "dq_out", dq_out, exp_d);
    slotprev = slot;
    n++;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog expired: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      do_reset(m[0], m[1]);
      for (int i = 0; i < NSEQ; i++) begin
        step(seq_cmd(i), (i == 19 || i == 20), (i == 24 || i == 30));
      end
    end
    finish_run();
  end
endmodule